// File: doc/BRIEF.md
# Reset Sequencer with Cause Register

This block decides which reset a small system is in and for how long. It watches five kinds of reset source: a general source (a power-on detect pulse or a supply-fault pulse), an exit from backup mode, a watchdog fault, a software command and a low level on the external reset pin. From these it drives a processor reset, a peripheral reset and a request to the pin shaper to pull the external reset line low. It records which source started the most recent reset in a 3-bit cause code.

When several sources are active at once, the one with the highest priority wins. Once a reset is running, a source of lower priority has no effect. A source of higher priority takes over and records its own cause. Every reset output stays asserted for a fixed number of slow-clock cycles after its source goes away. A small register port lets software issue reset commands, enable pin resets or a pin interrupt instead, read the status, and drive a key-protected pair of reset lines for a secondary core and its peripherals.

The sequencer is a three-state machine:
- ST_IDLE goes to ST_ASSERT when any source is active, taking the winning source's cause and output mask.
- ST_ASSERT goes to ST_STRETCH when its own source is no longer active.
- ST_STRETCH goes back to ST_ASSERT if its source returns. It goes to ST_IDLE once the hold count is used up.
- From ST_ASSERT or ST_STRETCH, a source of strictly higher priority restarts ST_ASSERT with the new cause.

Top module: `rst_sequencer`

## Requirements
- R1: The cause field is bits [2:0] of the status register (address 1). It holds general = 0, backup = 1, watchdog = 2, software = 3, user = 4. Other status bits are: bit 3 the pin interrupt flag, bit 4 the synchronised pin-low level, bit 5 busy.
- R2: A general reset (por_det or supply_fault high), a backup reset (backup_exit high) and a watchdog reset (wdt_fault high) each assert proc_rst, periph_rst and pin_drive_req.
- R3: When sources are active together, the priority from highest to lowest is general, backup, watchdog, software, user. The highest active source's code is recorded.
- R4: While a reset runs, a source of lower priority is ignored and the cause stays unchanged. A source of higher priority restarts the sequence and records its own code.
- R5: A source held for L sampled cycles gives reset outputs that are high for L+3 cycles, so the outputs stay asserted for 3 cycles after the source clears.
- R6: A write to address 0 issues a software reset. Bit 0 asserts proc_rst, bit 1 asserts periph_rst and bit 2 asserts pin_drive_req, each only when its bit is set. The cause becomes 3 and the outputs are high for 4 cycles.
- R7: With mode bit 0 (address 2) set, a low pin_in, after a two-flop synchroniser, asserts proc_rst and periph_rst but not pin_drive_req. The reset ends 3 cycles after the high pin is seen, and the cause becomes 4.
- R8: With mode bit 0 clear, a falling pin causes no reset and sets the status flag (bit 3). irq equals the flag AND mode bit 1.
- R9: A read of the status register clears the flag.
- R10: Register address 3 holds bit 0 = cop_periph_rst and bit 1 = cop_core_rst, both 1 after reset. A write changes them only when wdata[31:24] equals 0x5A.
- R11: After rst_n is released, proc_rst, periph_rst, pin_drive_req and irq are low, and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| por_det | input | 1 | Power-on detect pulse |
| supply_fault | input | 1 | Brownout or regulation-loss pulse |
| backup_exit | input | 1 | Backup-mode exit from supply logic |
| wdt_fault | input | 1 | Watchdog fault |
| pin_in | input | 1 | External reset pin level, 0 = low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| proc_rst | output | 1 | Processor reset |
| periph_rst | output | 1 | Peripheral reset |
| pin_drive_req | output | 1 | Request to pull the reset pin low |
| cop_core_rst | output | 1 | Secondary core reset |
| cop_periph_rst | output | 1 | Secondary core peripheral reset |
| irq | output | 1 | Pin interrupt, level |

## Verification
The assertions check the following on every cycle:
- A general source seen while idle records cause 0.
- The cause stays fixed unless a higher-priority source arrives.
- The machine never returns to idle before three quiet cycles have passed.
- A user reset drives both resets.
- A write with a wrong key leaves the secondary-core bits alone.
- A masked pin fall sets the flag, and a status read clears it.

Only the bench scenarios can show the exact output lengths through the synchroniser, the priority when sources start together, and that a software command issued during a watchdog reset is lost rather than deferred. The bench also checks, from the software side, the interrupt gating and the register readback.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        CAUSE_GENERAL  = 3'd0,
        CAUSE_BACKUP   = 3'd1,
        CAUSE_WATCHDOG = 3'd2,
        CAUSE_SOFTWARE = 3'd3,
        CAUSE_USER     = 3'd4
    } cause_e;

    localparam int NUM_SRC = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ASSERT,
        ST_STRETCH
    } seq_state_e;

    typedef struct packed {
        logic pin;
        logic periph;
        logic proc;
    } rst_mask_t;

    localparam logic [1:0] ADDR_CMD    = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_MODE   = 2'd2;
    localparam logic [1:0] ADDR_COCTL  = 2'd3;

endpackage

// File: rtl/rsq_pin_sampler.sv
module rsq_pin_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_low_s,
    output logic fall_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            low_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            low_q  <= pin_low_s;
        end
    end

    assign pin_low_s = ~sync_q[SYNC_STAGES-1];
    assign fall_evt  = pin_low_s & ~low_q;

endmodule

// File: rtl/rsq_seq_fsm.sv
module rsq_seq_fsm
    import rsq_pkg::*;
#(
    parameter int HOLD_CYCLES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_act,
    input  rst_mask_t             sw_mask,
    output logic                  proc_rst,
    output logic                  periph_rst,
    output logic                  pin_drive_req,
    output logic                  busy,
    output cause_e                cause
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam int QW    = CNT_W + 1;

    seq_state_e       state_q, state_d;
    cause_e           cause_q, cause_d;
    rst_mask_t        mask_q, mask_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             best_v;
    cause_e           best;
    logic             cur_active;

    function automatic rst_mask_t mask_for(cause_e c, rst_mask_t swm);
        rst_mask_t m;
        unique case (c)
            CAUSE_SOFTWARE: m = swm;
            CAUSE_USER:     m = '{pin: 1'b0, periph: 1'b1, proc: 1'b1};
            default:        m = '{pin: 1'b1, periph: 1'b1, proc: 1'b1};
        endcase
        return m;
    endfunction

    always_comb begin
        best_v = 1'b0;
        best   = CAUSE_USER;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (src_act[i]) begin
                best_v = 1'b1;
                best   = cause_e'(3'(i));
            end
        end
    end

    assign cur_active = src_act[cause_q];

    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        mask_d  = mask_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (best_v) begin
                    state_d = ST_ASSERT;
                    cause_d = best;
                    mask_d  = mask_for(best, sw_mask);
                    cnt_d   = '0;
                end
            end
            ST_ASSERT, ST_STRETCH: begin
                if (best_v && (best < cause_q)) begin
                    state_d = ST_ASSERT;
                    cause_d = best;
                    mask_d  = mask_for(best, sw_mask);
                    cnt_d   = '0;
                end else if (cur_active) begin
                    state_d = ST_ASSERT;
                    cnt_d   = '0;
                end else if (state_q == ST_ASSERT) begin
                    state_d = ST_STRETCH;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_W'(HOLD_CYCLES - 1)) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_GENERAL;
            mask_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            mask_q  <= mask_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy          = (state_q != ST_IDLE);
        proc_rst      = busy & mask_q.proc;
        periph_rst    = busy & mask_q.periph;
        pin_drive_req = busy & mask_q.pin;
        cause         = cause_q;
    end

    // quiet-cycle counter for the stretch check
    logic [QW-1:0] chk_quiet;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chk_quiet <= '0;
        else if (busy && !cur_active) begin
            if (chk_quiet != QW'(HOLD_CYCLES))
                chk_quiet <= chk_quiet + 1'b1;
        end else
            chk_quiet <= '0;
    end

    assert_general_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && src_act[0]) |=> cause_q == CAUSE_GENERAL);

    assert_lower_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(best_v && best < cause_q)) |=> $stable(cause_q));

    assert_stretch_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_d == ST_IDLE) |-> chk_quiet >= QW'(HOLD_CYCLES));

    assert_user_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cause_q == CAUSE_USER) |-> (proc_rst && periph_rst && !pin_drive_req));

endmodule

// File: rtl/rsq_regs.sv
module rsq_regs
    import rsq_pkg::*;
#(
    parameter logic [7:0] KEY = 8'h5A,
    parameter int         DW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  cause_e        cause,
    input  logic          busy,
    input  logic          pin_low_s,
    input  logic          fall_evt,
    output logic          sw_pulse,
    output rst_mask_t     sw_mask,
    output logic          user_en,
    output logic          irq,
    output logic          cop_core_rst,
    output logic          cop_periph_rst
);
    logic       sw_pulse_q;
    logic [2:0] sw_mask_q;
    logic       user_en_q, irq_en_q, flag_q;
    logic [1:0] coctl_q;
    logic       wr_cmd, wr_mode, wr_coctl, key_ok, rd_stat, flag_set;

    assign wr_cmd   = reg_wr && reg_addr == ADDR_CMD && reg_wdata[2:0] != 3'b000;
    assign wr_mode  = reg_wr && reg_addr == ADDR_MODE;
    assign key_ok   = reg_wdata[DW-1 -: 8] == KEY;
    assign wr_coctl = reg_wr && reg_addr == ADDR_COCTL && key_ok;
    assign rd_stat  = reg_rd && reg_addr == ADDR_STATUS;
    assign flag_set = fall_evt && !user_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_pulse_q <= 1'b0;
            sw_mask_q  <= '0;
            user_en_q  <= 1'b0;
            irq_en_q   <= 1'b0;
            flag_q     <= 1'b0;
            coctl_q    <= 2'b11;
        end else begin
            sw_pulse_q <= wr_cmd;
            if (wr_cmd)
                sw_mask_q <= reg_wdata[2:0];
            if (wr_mode) begin
                user_en_q <= reg_wdata[0];
                irq_en_q  <= reg_wdata[1];
            end
            if (wr_coctl)
                coctl_q <= reg_wdata[1:0];
            if (flag_set)
                flag_q <= 1'b1;
            else if (rd_stat)
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_STATUS: reg_rdata[5:0] = {busy, pin_low_s, flag_q, 3'(cause)};
            ADDR_MODE:   reg_rdata[1:0] = {irq_en_q, user_en_q};
            ADDR_COCTL:  reg_rdata[1:0] = coctl_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign sw_pulse       = sw_pulse_q;
    assign sw_mask        = rst_mask_t'(sw_mask_q);
    assign user_en        = user_en_q;
    assign irq            = flag_q & irq_en_q;
    assign cop_periph_rst = coctl_q[0];
    assign cop_core_rst   = coctl_q[1];

    assert_bad_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_COCTL && !key_ok) |=> $stable(coctl_q));

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_evt && !user_en_q) |=> flag_q);

    assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !flag_set) |=> !flag_q);

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rsq_pkg::*;
#(
    parameter int         HOLD_CYCLES = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] KEY         = 8'h5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_det,
    input  logic        supply_fault,
    input  logic        backup_exit,
    input  logic        wdt_fault,
    input  logic        pin_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        proc_rst,
    output logic        periph_rst,
    output logic        pin_drive_req,
    output logic        cop_core_rst,
    output logic        cop_periph_rst,
    output logic        irq
);
    logic               pin_low_s, fall_evt, sw_pulse, user_en, busy;
    rst_mask_t          sw_mask;
    cause_e             cause;
    logic [NUM_SRC-1:0] src_act;

    rsq_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .pin_low_s (pin_low_s),
        .fall_evt  (fall_evt)
    );

    // index equals cause code, lowest index wins
    assign src_act = {pin_low_s & user_en, sw_pulse, wdt_fault, backup_exit,
                      por_det | supply_fault};

    rsq_seq_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_act       (src_act),
        .sw_mask       (sw_mask),
        .proc_rst      (proc_rst),
        .periph_rst    (periph_rst),
        .pin_drive_req (pin_drive_req),
        .busy          (busy),
        .cause         (cause)
    );

    rsq_regs #(.KEY(KEY), .DW(32)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr         (reg_wr),
        .reg_rd         (reg_rd),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .cause          (cause),
        .busy           (busy),
        .pin_low_s      (pin_low_s),
        .fall_evt       (fall_evt),
        .sw_pulse       (sw_pulse),
        .sw_mask        (sw_mask),
        .user_en        (user_en),
        .irq            (irq),
        .cop_core_rst   (cop_core_rst),
        .cop_periph_rst (cop_periph_rst)
    );

endmodule

// File: tb/sim_rst_sequencer.sv
module sim_rst_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_det = 0, supply_fault = 0, backup_exit = 0, wdt_fault = 0;
    logic        pin_in = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [1:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        proc_rst, periph_rst, pin_drive_req, cop_core_rst, cop_periph_rst, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rst_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .por_det(por_det), .supply_fault(supply_fault),
        .backup_exit(backup_exit), .wdt_fault(wdt_fault), .pin_in(pin_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .proc_rst(proc_rst), .periph_rst(periph_rst),
        .pin_drive_req(pin_drive_req), .cop_core_rst(cop_core_rst),
        .cop_periph_rst(cop_periph_rst), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mask bits: 0 por, 1 backup, 2 watchdog, 4 pin low, 5 supply fault
    function automatic int exp_cause(logic [5:0] m);
        if (m[0] || m[5]) return 0;
        if (m[1]) return 1;
        if (m[2]) return 2;
        return 4;
    endfunction

    function automatic int exp_len(int len);
        return len + 3;
    endfunction

    task automatic set_src(logic [5:0] m, logic v);
        if (m[0]) por_det = v;
        if (m[1]) backup_exit = v;
        if (m[2]) wdt_fault = v;
        if (m[4]) pin_in = !v;
        if (m[5]) supply_fault = v;
    endtask

    task automatic run_src(logic [5:0] m, int len, output int cp, output int cr, output int cn);
        cp = 0; cr = 0; cn = 0;
        @(negedge clk);
        set_src(m, 1'b1);
        for (int i = 0; i < len + 20; i++) begin
            @(negedge clk);
            cp += int'(proc_rst);
            cr += int'(periph_rst);
            cn += int'(pin_drive_req);
            if (i == len - 1) set_src(m, 1'b0);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic count_win(int n, output int cp, output int cr, output int cn);
        cp = 0; cr = 0; cn = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cp += int'(proc_rst);
            cr += int'(periph_rst);
            cn += int'(pin_drive_req);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cp, cr, cn, len;
        logic [1:0] exp_cop;
        logic [5:0] m;
        void'($urandom(32'h00C0FFEE));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 proc_rst", proc_rst, 0);
        check("R11 periph_rst", periph_rst, 0);
        check("R11 pin_drive_req", pin_drive_req, 0);
        check("R11 irq", irq, 0);
        reg_read(2'd1, d);
        check("R11 status", d, 0);
        check("R10 cop reset value", {cop_core_rst, cop_periph_rst}, 2'b11);

        // R2 R5 watchdog pulse
        run_src(6'b000100, 1, cp, cr, cn);
        check("R5 watchdog len", cp, 4);
        check("R2 watchdog periph", cr, 4);
        check("R2 watchdog pin", cn, 4);
        reg_read(2'd1, d);
        check("R1 watchdog cause", d[2:0], 2);

        // R2 supply fault, held 5
        run_src(6'b100000, 5, cp, cr, cn);
        check("R5 general len", cp, 8);
        reg_read(2'd1, d);
        check("R1 general cause", d[2:0], 0);

        // R3 priority with simultaneous sources
        reg_write(2'd2, 32'h1);
        run_src(6'b010110, 2, cp, cr, cn);
        reg_read(2'd1, d);
        check("R3 backup over watchdog/user", d[2:0], 1);
        run_src(6'b010111, 2, cp, cr, cn);
        reg_read(2'd1, d);
        check("R3 general over all", d[2:0], 0);
        reg_write(2'd2, 32'h0);

        // R4 lower ignored: software during watchdog
        @(negedge clk); wdt_fault = 1;
        repeat (2) @(negedge clk);
        reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h3;
        @(negedge clk); reg_wr = 0;
        repeat (3) @(negedge clk); wdt_fault = 0;
        repeat (8) @(negedge clk);
        check("R4 no deferred reset", proc_rst, 0);
        reg_read(2'd1, d);
        check("R4 cause kept", d[2:0], 2);

        // R4 higher preempts: backup during watchdog
        @(negedge clk); wdt_fault = 1;
        repeat (2) @(negedge clk); backup_exit = 1;
        @(negedge clk); backup_exit = 0;
        repeat (2) @(negedge clk); wdt_fault = 0;
        repeat (8) @(negedge clk);
        reg_read(2'd1, d);
        check("R4 preempt cause", d[2:0], 1);

        // R6 software resets
        reg_write(2'd0, 32'h1);
        count_win(10, cp, cr, cn);
        check("R6 sw proc len", cp, 4);
        check("R6 sw periph off", cr, 0);
        check("R6 sw pin off", cn, 0);
        reg_read(2'd1, d);
        check("R6 sw cause", d[2:0], 3);
        reg_write(2'd0, 32'h4);
        count_win(10, cp, cr, cn);
        check("R6 sw pin len", cn, 4);
        check("R6 sw pin only proc", cp, 0);

        // R7 user reset
        reg_write(2'd2, 32'h1);
        run_src(6'b010000, 6, cp, cr, cn);
        check("R7 user proc len", cp, 9);
        check("R7 user periph len", cr, 9);
        check("R7 user no pin drive", cn, 0);
        reg_read(2'd1, d);
        check("R7 user cause", d[2:0], 4);

        // R8 R9 masked pin with interrupt
        reg_write(2'd2, 32'h2);
        run_src(6'b010000, 4, cp, cr, cn);
        check("R8 masked no reset", cp, 0);
        check("R8 irq set", irq, 1);
        reg_read(2'd1, d);
        check("R8 flag bit", d[3], 1);
        check("R9 irq cleared by read", irq, 0);
        reg_read(2'd1, d);
        check("R9 flag cleared", d[3], 0);
        reg_write(2'd2, 32'h0);
        run_src(6'b010000, 3, cp, cr, cn);
        check("R8 irq gated", irq, 0);
        reg_read(2'd1, d);
        check("R8 flag without irq", d[3], 1);

        // R10 key protection
        reg_write(2'd3, 32'h5A00_0000);
        check("R10 good key", {cop_core_rst, cop_periph_rst}, 2'b00);
        reg_write(2'd3, 32'h5B00_0003);
        check("R10 bad key", {cop_core_rst, cop_periph_rst}, 2'b00);
        exp_cop = 2'b00;

        // random mix
        reg_write(2'd2, 32'h1);
        for (int it = 0; it < 60; it++) begin
            int k;
            k = int'($urandom_range(0, 5));
            len = int'($urandom_range(1, 6));
            if (k == 3) begin
                reg_write(2'd0, 32'h1);
                count_win(10, cp, cr, cn);
                check("R6 random sw len", cp, 4);
                reg_read(2'd1, d);
                check("R1 random sw cause", d[2:0], 3);
            end else begin
                m = 6'b0;
                m[k] = 1'b1;
                run_src(m, len, cp, cr, cn);
                check("R5 random len", cp, exp_len(len));
                reg_read(2'd1, d);
                check("R3 random cause", d[2:0], exp_cause(m));
            end
            begin
                logic [1:0] v;
                logic good;
                v = 2'($urandom_range(0, 3));
                good = 1'($urandom_range(0, 1));
                reg_write(2'd3, {good ? 8'h5A : 8'hA5, 22'd0, v});
                if (good) exp_cop = v;
                check("R10 random cop", {cop_core_rst, cop_periph_rst}, exp_cop);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule